// File: doc/BRIEF.md
# Serial Pattern Detector with Hit Tallies

This block watches a serial bit stream that arrives one bit per clock. It runs two pattern recognisers side by side on the same stream. The first is a state-output recogniser that reports the pattern 0101. The second is an input-dependent recogniser that reports the pattern 010101. Both recognisers allow matches to overlap.

Each recogniser's hit flag drives its own event counter. The two counts are packed into one word that a display driver can show as hex digits. The 0101 count sits in the upper byte, which is digits 3:2. The 010101 count sits in the lower byte, which is digits 1:0.

The reset input is active low. It clears the block at once, without waiting for a clock. Its release is passed through a two-stage synchroniser, so the block starts running only on the second rising clock edge after the reset input goes high.

Top module: `seq_hit_tally`

## Requirements
- R1: `moore_hit` goes to 1 for exactly the clock cycle that follows the edge that took in the final 1 of 0101. It depends only on the stored state, so changing `bit_in` within a cycle does not change it.
- R2: Matches of 0101 may overlap. After 0101, each further 01 produces another `moore_hit`, so two hits are never on consecutive cycles.
- R3: `mealy_hit` is 1 within the same cycle in which the final 1 of 010101 is present on `bit_in`. It is never 1 while `bit_in` is 0.
- R4: Matches of 010101 may overlap. After 010101, each further 01 produces another `mealy_hit`, so two hits are never on consecutive cycles.
- R5: On each rising clock edge where a hit flag is 1, the counter of that recogniser increases by one. On any other edge it holds its value.
- R6: Each counter is 8 bits wide and wraps from FF to 00 on its next hit.
- R7: `tally[15:8]` holds the 0101 hit count and `tally[7:0]` holds the 010101 hit count.
- R8: While `rst_n` is 0, both recognisers sit in their idle state and both counters and both flags read 0. This applies from the moment `rst_n` falls, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one stream bit is taken on each rising edge |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, its release is synchronised |
| bit_in | input | 1 | Serial stream bit |
| moore_hit | output | 1 | State-only flag for pattern 0101 |
| mealy_hit | output | 1 | State-and-input flag for pattern 010101 |
| tally | output | 16 | {0101 hit count, 010101 hit count} |

## Verification
Every 8-bit word from 00 to FF is fed serially, back to back, as one 2048-bit stream. This covers every short ordering of zeros and ones, so it exposes wrong transitions on partial matches and any fall back to idle where an overlap should be kept. Mid-cycle toggling of the input separates the state-only flag, which must not move, from the input-dependent flag, which must follow the input. A long run of repeated 01 makes both counters hit on every second bit and carries them through FF back to 00. A reset in the middle of a stream checks that the flags and counts clear without a clock edge.

// File: rtl/seq_tally_pkg.sv
package seq_tally_pkg;

  // Progress of the 0101 recogniser; P4 means a full match is held.
  typedef enum logic [2:0] {
    MO_P0 = 3'd0,
    MO_P1 = 3'd1,
    MO_P2 = 3'd2,
    MO_P3 = 3'd3,
    MO_P4 = 3'd4
  } moore_st_e;

  // Matched prefix length of 010101 (0..5); a hit fires from L5 on a 1.
  typedef enum logic [2:0] {
    ME_L0 = 3'd0,
    ME_L1 = 3'd1,
    ME_L2 = 3'd2,
    ME_L3 = 3'd3,
    ME_L4 = 3'd4,
    ME_L5 = 3'd5
  } mealy_st_e;

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_int_n = chain_q[STAGES-1];
endmodule

// File: rtl/seq_moore_det.sv
module seq_moore_det
  import seq_tally_pkg::*;
(
  input  logic clk,
  input  logic rst_int_n,
  input  logic din,
  output logic hit
);
  moore_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      MO_P0:   st_d = din ? MO_P0 : MO_P1;
      MO_P1:   st_d = din ? MO_P2 : MO_P1;
      MO_P2:   st_d = din ? MO_P0 : MO_P3;
      MO_P3:   st_d = din ? MO_P4 : MO_P1;
      MO_P4:   st_d = din ? MO_P0 : MO_P3;  // keep "010" on overlap
      default: st_d = MO_P0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) st_q <= MO_P0;
    else            st_q <= st_d;
  end

  assign hit = (st_q == MO_P4);
endmodule

// File: rtl/seq_mealy_det.sv
module seq_mealy_det
  import seq_tally_pkg::*;
(
  input  logic clk,
  input  logic rst_int_n,
  input  logic din,
  output logic hit
);
  mealy_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ME_L0:   st_d = din ? ME_L0 : ME_L1;
      ME_L1:   st_d = din ? ME_L2 : ME_L1;
      ME_L2:   st_d = din ? ME_L0 : ME_L3;
      ME_L3:   st_d = din ? ME_L4 : ME_L1;
      ME_L4:   st_d = din ? ME_L0 : ME_L5;
      ME_L5:   st_d = din ? ME_L4 : ME_L1;  // hit; keep "0101" on overlap
      default: st_d = ME_L0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) st_q <= ME_L0;
    else            st_q <= st_d;
  end

  assign hit = (st_q == ME_L5) && din;
endmodule

// File: rtl/seq_hit_counter.sv
module seq_hit_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_int_n,
  input  logic             en,
  output logic [WIDTH-1:0] count
);
  logic [WIDTH-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + {{(WIDTH-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) cnt_q <= '0;
    else if (en)    cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/seq_hit_tally.sv
module seq_hit_tally #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int TALLY_W    = 2 * CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_in,
  output logic               moore_hit,
  output logic               mealy_hit,
  output logic [TALLY_W-1:0] tally
);
  logic             rst_int_n;
  logic [CNT_W-1:0] moore_cnt;
  logic [CNT_W-1:0] mealy_cnt;

  seq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  seq_moore_det u_moore (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .din       (bit_in),
    .hit       (moore_hit)
  );

  seq_mealy_det u_mealy (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .din       (bit_in),
    .hit       (mealy_hit)
  );

  seq_hit_counter #(.WIDTH(CNT_W)) u_moore_cnt (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .en        (moore_hit),
    .count     (moore_cnt)
  );

  seq_hit_counter #(.WIDTH(CNT_W)) u_mealy_cnt (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .en        (mealy_hit),
    .count     (mealy_cnt)
  );

  assign tally = {moore_cnt, mealy_cnt};
endmodule

// File: rtl/seq_hit_tally_chk.sv
module seq_hit_tally_chk #(
  parameter int CNT_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bit_in,
  input logic               moore_hit,
  input logic               mealy_hit,
  input logic [2*CNT_W-1:0] tally
);
  logic [CNT_W-1:0] hi_cnt;
  logic [CNT_W-1:0] lo_cnt;
  assign hi_cnt = tally[2*CNT_W-1:CNT_W];
  assign lo_cnt = tally[CNT_W-1:0];

  AST_MOORE_AFTER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    moore_hit |-> $past(bit_in)); // R1
  AST_MOORE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    moore_hit |=> !moore_hit); // R2
  AST_MEALY_NEEDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    mealy_hit |-> bit_in); // R3
  AST_MEALY_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    mealy_hit |=> !mealy_hit); // R4
  AST_HI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    moore_hit |=> hi_cnt == CNT_W'($past(hi_cnt) + 1'b1)); // R5
  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !moore_hit |=> $stable(hi_cnt)); // R5
  AST_LO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mealy_hit |=> lo_cnt == CNT_W'($past(lo_cnt) + 1'b1)); // R5
  AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mealy_hit |=> $stable(lo_cnt)); // R5
  AST_HI_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (moore_hit && hi_cnt == '1) |=> hi_cnt == '0); // R6
  AST_LO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mealy_hit && lo_cnt == '1) |=> lo_cnt == '0); // R6
endmodule

bind seq_hit_tally seq_hit_tally_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_in    (bit_in),
  .moore_hit (moore_hit),
  .mealy_hit (mealy_hit),
  .tally     (tally)
);

// File: tb/tb_seq_hit_tally.sv
module tb_seq_hit_tally;
  logic        clk;
  logic        rst_n;
  logic        bit_in;
  logic        moore_hit;
  logic        mealy_hit;
  logic [15:0] tally;

  int          n_chk;
  int          n_bad;
  logic [5:0]  hist;
  logic [7:0]  exp_hi;
  logic [7:0]  exp_lo;
  bit          done;

  seq_hit_tally dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_in    (bit_in),
    .moore_hit (moore_hit),
    .mealy_hit (mealy_hit),
    .tally     (tally)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    hist   = 6'b111111;
    exp_hi = 8'h00;
    exp_lo = 8'h00;
  endtask

  // Called at a negedge. Checks the state flag and counts, drives one bit,
  // checks the input-dependent flag, then steps past the next rising edge.
  task automatic send_bit(input logic b);
    logic mo_now;
    logic me_now;
    mo_now = (hist[3:0] == 4'b0101);
    check("R1 moore_hit", {15'd0, moore_hit}, {15'd0, mo_now});
    check("R5 R7 tally", tally, {exp_hi, exp_lo});
    bit_in = b;
    #1;
    me_now = ({hist[4:0], b} == 6'b010101);
    check("R1 moore_hit stable vs bit_in", {15'd0, moore_hit}, {15'd0, mo_now});
    check("R3 R4 mealy_hit", {15'd0, mealy_hit}, {15'd0, me_now});
    if (mo_now) exp_hi = exp_hi + 8'd1;
    if (me_now) exp_lo = exp_lo + 8'd1;
    hist = {hist[4:0], b};
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    n_chk  = 0;
    n_bad  = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    bit_in = 1'b1;
    model_clear();
    #2;
    check("R8 reset flags", {14'd0, moore_hit, mealy_hit}, 16'd0);
    check("R8 reset tally", tally, 16'd0);
    repeat (2) @(negedge clk);
    release_reset();
    check("R8 idle after release", {moore_hit, mealy_hit, tally[13:0]}, 16'd0);

    // Every 8-bit word, MSB first, as one continuous stream (R1..R5, R7).
    for (int w = 0; w < 256; w++) begin
      for (int i = 7; i >= 0; i--) send_bit(w[i]);
    end

    // Long 01 run to carry both counters past FF (R2, R4, R6).
    for (int k = 0; k < 300; k++) begin
      send_bit(1'b0);
      send_bit(1'b1);
    end
    send_bit(1'b1);

    // Mid-stream asynchronous reset (R8).
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    rst_n = 1'b0;
    #1;
    check("R8 async clear flags", {14'd0, moore_hit, mealy_hit}, 16'd0);
    check("R8 async clear tally", tally, 16'd0);
    bit_in = 1'b1;
    model_clear();
    @(negedge clk);
    release_reset();
    for (int k = 0; k < 4; k++) begin
      send_bit(1'b0);
      send_bit(1'b1);
    end
    send_bit(1'b1);
    check("R6 R7 final tally", tally, {exp_hi, exp_lo});
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule